// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in an unpacked working form and turns it into a 32-bit IEEE-754 single-precision word. The working form has a two-bit class, a sign, a signed unbiased exponent, a left-aligned mantissa whose top bit is the integer bit, and a sticky bit. The sticky bit stands for nonzero bits already lost further down. The block handles zeros, infinities and NaNs. For finite numbers it aligns the mantissa, rounds under one of four rounding modes, and chooses the normal, subnormal or overflow encoding.

Alongside the word it reports three flags: inexact, overflow and underflow. An input enabling the underflow trap changes only when the underflow flag is raised. The block does not trap. It sits at the end of an arithmetic pipeline. A result offered with `in_valid` comes out, registered, on the next clock.

Top module: `sp_result_packer`

## Requirements
- R1: A result and its flags appear on the outputs, with `out_valid` high, on the clock edge after the edge that samples `in_valid` high. In every cycle that follows a cycle with `in_valid` low, `out_valid` is low and the word and flags keep their previous values, whatever the other inputs carry.
- R2: Class encoding is 0 = zero, 1 = finite number, 2 = infinity, 3 = NaN. A zero class gives a word holding only the sign in bit 31, with all flags clear.
- R3: An infinity class gives sign, exponent field 255 and fraction 0, with all flags clear.
- R4: A NaN class gives exponent field 255. Its fraction takes the 23 mantissa bits below the integer bit without rounding, and bit 22 is forced to 1. All flags stay clear, even when lower mantissa bits are nonzero.
- R5: For a finite number, the biased exponent is the unbiased exponent plus 127. With a biased exponent from 1 to 254, the word is sign, biased exponent in bits 30:23, and the 23 mantissa bits below the integer bit in bits 22:0.
- R6: Rounding mode encoding is 0 = nearest with ties to even, 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity. The guard bit is the first bit below the kept fraction, the round bit the next one, and every lower bit together with `in_sticky` forms the sticky. Inexact is raised whenever guard, round or sticky is nonzero.
- R7: On the normal path, if rounding carries the significand to 2.0, the exponent field rises by one and the fraction becomes 0.
- R8: If the final biased exponent is 255 or more, overflow and inexact are both set. The word is infinity in mode 0, in mode 2 with a positive sign, and in mode 3 with a negative sign. Otherwise it is the largest finite magnitude, exponent field 254 and fraction all ones.
- R9: A biased exponent of 0 or below takes the subnormal path. There the integer bit moves into the fraction with 1 − (biased exponent) extra leading zeros, the bits shifted out feed the sticky, and rounding follows R6. The result has exponent field 0.
- R10: If rounding a subnormal carries into bit 23, the word is the smallest normal: the sign, exponent field 1 and fraction 0. Underflow stays clear in this case.
- R11: A result that stays subnormal raises underflow exactly when it is inexact or `uf_trap_en` is high. Normal, overflow and special results never raise underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Offers a result this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa, integer bit at the top |
| in_sticky | input | 1 | Nonzero bits already lost below the mantissa |
| rnd_mode | input | 2 | Rounding mode, encoded as in R6 |
| uf_trap_en | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Packed word and flags are new this cycle |
| out_word | output | 32 | Packed single-precision word |
| flag_nx | output | 1 | Inexact |
| flag_of | output | 1 | Overflow |
| flag_uf | output | 1 | Underflow |

## Verification
Each result is due exactly one clock after the edge that samples it, because a single register sits between the inputs and every output. The bench changes inputs on falling edges and lowers `in_valid` on the next falling edge. It then reads word, flags and `out_valid` in that same low phase, which is half a period after the edge that captured them. The idle check drives new inputs with `in_valid` low and reads again one falling edge later. That confirms the word stayed put and `out_valid` fell in the very next cycle.

// File: rtl/sp_result_packer.sv
module sp_result_packer #(
  parameter int MANT_W = 32,
  parameter int EXP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic                    in_sticky,
  input  logic [1:0]              rnd_mode,
  input  logic                    uf_trap_en,
  output logic                    out_valid,
  output logic [31:0]             out_word,
  output logic                    flag_nx,
  output logic                    flag_of,
  output logic                    flag_uf
);

  localparam int KEEP_W  = 26;
  localparam int BASE_SH = MANT_W - KEEP_W;
  localparam int BIAS    = 127;
  localparam int EXP_TOP = 255;
  localparam int WIDE_W  = MANT_W + KEEP_W;

  localparam logic [1:0] CLS_ZERO = 2'd0;
  localparam logic [1:0] CLS_NUM  = 2'd1;
  localparam logic [1:0] CLS_INF  = 2'd2;
  localparam logic [1:0] CLS_NAN  = 2'd3;

  localparam logic [1:0] RM_NEAR = 2'd0;
  localparam logic [1:0] RM_ZERO = 2'd1;
  localparam logic [1:0] RM_UP   = 2'd2;
  localparam logic [1:0] RM_DOWN = 2'd3;

  int                biased;
  int                extra_sh;
  int                final_exp;
  logic              is_sub;
  logic [WIDE_W-1:0] aligned;
  logic [KEEP_W-1:0] kept;
  logic              sticky_all;
  logic              inexact;
  logic              bump;
  logic [24:0]       rounded;
  logic              go_inf;
  logic [31:0]       res_word;
  logic              res_nx;
  logic              res_of;
  logic              res_uf;

  assign biased = int'(in_exp) + BIAS;
  assign is_sub = (biased <= 0);

  always_comb begin
    if (!is_sub)              extra_sh = 0;
    else if (biased < -KEEP_W) extra_sh = KEEP_W;
    else                       extra_sh = (1 - biased > KEEP_W) ? KEEP_W : 1 - biased;
  end

  assign aligned    = {in_mant, {KEEP_W{1'b0}}} >> extra_sh;
  assign kept       = aligned[WIDE_W-1:MANT_W];
  assign sticky_all = (|aligned[MANT_W-1:0]) | in_sticky;
  assign inexact    = kept[1] | kept[0] | sticky_all;

  always_comb begin
    case (rnd_mode)
      RM_NEAR: bump = kept[1] & (kept[0] | sticky_all | kept[2]);
      RM_ZERO: bump = 1'b0;
      RM_UP:   bump = ~in_sign & inexact;
      default: bump = in_sign & inexact;
    endcase
  end

  assign rounded   = {1'b0, kept[KEEP_W-1:2]} + {24'd0, bump};
  assign final_exp = biased + (rounded[24] ? 1 : 0);

  always_comb begin
    case (rnd_mode)
      RM_NEAR: go_inf = 1'b1;
      RM_ZERO: go_inf = 1'b0;
      RM_UP:   go_inf = ~in_sign;
      default: go_inf = in_sign;
    endcase
  end

  always_comb begin
    res_word = {in_sign, 31'd0};
    res_nx   = 1'b0;
    res_of   = 1'b0;
    res_uf   = 1'b0;
    case (in_class)
      CLS_ZERO: res_word = {in_sign, 31'd0};
      CLS_INF:  res_word = {in_sign, 8'hFF, 23'd0};
      CLS_NAN:  res_word = {in_sign, 8'hFF, 1'b1, in_mant[MANT_W-3 -: 22]};
      CLS_NUM: begin
        res_nx = inexact;
        if (is_sub) begin
          if (rounded[23]) begin
            res_word = {in_sign, 8'h01, 23'd0};
          end else begin
            res_word = {in_sign, 8'h00, rounded[22:0]};
            res_uf   = inexact | uf_trap_en;
          end
        end else if (final_exp >= EXP_TOP) begin
          res_of   = 1'b1;
          res_nx   = 1'b1;
          res_word = go_inf ? {in_sign, 8'hFF, 23'd0} : {in_sign, 8'hFE, 23'h7FFFFF};
        end else begin
          res_word = {in_sign, final_exp[7:0], rounded[22:0]};
        end
      end
      default: res_word = {in_sign, 31'd0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= 32'd0;
      flag_nx   <= 1'b0;
      flag_of   <= 1'b0;
      flag_uf   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= res_word;
        flag_nx  <= res_nx;
        flag_of  <= res_of;
        flag_uf  <= res_uf;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word) && $stable(flag_uf)));
  assert_zero_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == CLS_ZERO) |=>
      (out_word[30:0] == 31'd0 && !flag_nx && !flag_of && !flag_uf));
  assert_nan_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == CLS_NAN) |=> (out_word[30:22] == 9'h1FF && !flag_nx));
  assert_sign_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_word[31] == $past(in_sign)));
  assert_of_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_of) |-> (flag_nx && out_word[30:23] >= 8'hFE && !flag_uf));
  assert_uf_subnormal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_uf) |-> (out_word[30:23] == 8'h00));

endmodule

// File: tb/sp_result_packer_tb.sv
module sp_result_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 32;
  localparam int EW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0]        in_class = 2'd0;
  logic              in_sign = 1'b0;
  logic signed [EW-1:0] in_exp = '0;
  logic [MW-1:0]     in_mant = '0;
  logic              in_sticky = 1'b0;
  logic [1:0]        rnd_mode = 2'd0;
  logic              uf_trap_en = 1'b0;
  logic              out_valid;
  logic [31:0]       out_word;
  logic              flag_nx, flag_of, flag_uf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sp_result_packer #(.MANT_W(MW), .EXP_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .rnd_mode(rnd_mode), .uf_trap_en(uf_trap_en), .out_valid(out_valid),
    .out_word(out_word), .flag_nx(flag_nx), .flag_of(flag_of), .flag_uf(flag_uf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] cls, input logic sgn, input int e,
                     input logic [31:0] m, input logic stk, input logic [1:0] mode,
                     input logic trap, input logic [31:0] w, input logic nx,
                     input logic of, input logic uf);
    @(negedge clk);
    in_valid = 1'b1; in_class = cls; in_sign = sgn; in_exp = EW'(e);
    in_mant = m; in_sticky = stk; rnd_mode = mode; uf_trap_en = trap;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, out_word, flag_nx, flag_of, flag_uf}, {1'b1, w, nx, of, uf});
  endtask

  task automatic t_reset;
    check("R1 reset", {out_valid, out_word, flag_nx, flag_of, flag_uf}, 36'd0);
  endtask

  task automatic t_specials;
    run("R2 zero", 2'd0, 1'b1, 5, 32'hFFFF_FFFF, 1'b1, 2'd0, 1'b1, 32'h8000_0000, 0, 0, 0);
    run("R3 inf", 2'd2, 1'b0, 0, 32'h8000_0000, 1'b0, 2'd1, 1'b0, 32'h7F80_0000, 0, 0, 0);
    run("R3 inf neg", 2'd2, 1'b1, 0, 32'h8000_0000, 1'b0, 2'd0, 1'b0, 32'hFF80_0000, 0, 0, 0);
    run("R4 nan payload", 2'd3, 1'b0, 0, 32'h8123_4567, 1'b1, 2'd0, 1'b1, 32'h7FC1_2345, 0, 0, 0);
    run("R4 nan truncate", 2'd3, 1'b1, 0, 32'hBFFF_FFFF, 1'b0, 2'd2, 1'b0, 32'hFFFF_FFFF, 0, 0, 0);
  endtask

  task automatic t_normal;
    run("R5 one", 2'd1, 1'b0, 0, 32'h8000_0000, 1'b0, 2'd0, 1'b0, 32'h3F80_0000, 0, 0, 0);
    run("R5 bits", 2'd1, 1'b1, 3, 32'hC000_0000, 1'b0, 2'd0, 1'b1, 32'hC140_0000, 0, 0, 0);
    run("R5 min normal", 2'd1, 1'b0, -126, 32'h8000_0000, 1'b0, 2'd0, 1'b1, 32'h0080_0000, 0, 0, 0);
  endtask

  task automatic t_round;
    run("R6 tie odd up", 2'd1, 1'b0, 0, 32'h8000_0180, 1'b0, 2'd0, 1'b0, 32'h3F80_0002, 1, 0, 0);
    run("R6 tie even down", 2'd1, 1'b0, 0, 32'h8000_0080, 1'b0, 2'd0, 1'b0, 32'h3F80_0000, 1, 0, 0);
    run("R6 near sticky", 2'd1, 1'b1, 0, 32'h8000_0001, 1'b0, 2'd0, 1'b0, 32'hBF80_0000, 1, 0, 0);
    run("R6 zero mode", 2'd1, 1'b1, 0, 32'h8000_00FF, 1'b0, 2'd1, 1'b0, 32'hBF80_0000, 1, 0, 0);
    run("R6 up neg", 2'd1, 1'b1, 0, 32'h8000_0001, 1'b0, 2'd2, 1'b0, 32'hBF80_0000, 1, 0, 0);
    run("R6 down neg", 2'd1, 1'b1, 0, 32'h8000_0001, 1'b0, 2'd3, 1'b0, 32'hBF80_0001, 1, 0, 0);
    run("R6 up pos", 2'd1, 1'b0, 0, 32'h8000_0001, 1'b0, 2'd2, 1'b0, 32'h3F80_0001, 1, 0, 0);
    run("R6 in_sticky", 2'd1, 1'b0, 0, 32'h8000_0000, 1'b1, 2'd2, 1'b0, 32'h3F80_0001, 1, 0, 0);
  endtask

  task automatic t_carry;
    run("R7 carry", 2'd1, 1'b0, 0, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0, 32'h4000_0000, 1, 0, 0);
  endtask

  task automatic t_overflow;
    run("R8 round to inf", 2'd1, 1'b0, 127, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0, 32'h7F80_0000, 1, 1, 0);
    run("R8 zero no of", 2'd1, 1'b0, 127, 32'hFFFF_FFFF, 1'b0, 2'd1, 1'b0, 32'h7F7F_FFFF, 1, 0, 0);
    run("R8 zero max", 2'd1, 1'b0, 128, 32'h8000_0000, 1'b0, 2'd1, 1'b0, 32'h7F7F_FFFF, 1, 1, 0);
    run("R8 up neg max", 2'd1, 1'b1, 128, 32'h8000_0000, 1'b0, 2'd2, 1'b0, 32'hFF7F_FFFF, 1, 1, 0);
    run("R8 down neg inf", 2'd1, 1'b1, 128, 32'h8000_0000, 1'b0, 2'd3, 1'b0, 32'hFF80_0000, 1, 1, 0);
    run("R8 up pos inf", 2'd1, 1'b0, 128, 32'h8000_0000, 1'b0, 2'd2, 1'b0, 32'h7F80_0000, 1, 1, 0);
    run("R8 down pos max", 2'd1, 1'b0, 128, 32'h8000_0000, 1'b0, 2'd3, 1'b0, 32'h7F7F_FFFF, 1, 1, 0);
    run("R8 huge exp", 2'd1, 1'b1, 1000, 32'h8000_0000, 1'b0, 2'd0, 1'b1, 32'hFF80_0000, 1, 1, 0);
  endtask

  task automatic t_subnormal;
    run("R9 half exact", 2'd1, 1'b0, -127, 32'h8000_0000, 1'b0, 2'd0, 1'b0, 32'h0040_0000, 0, 0, 0);
    run("R9 min sub", 2'd1, 1'b1, -149, 32'h8000_0000, 1'b0, 2'd0, 1'b0, 32'h8000_0001, 0, 0, 0);
    run("R9 tie to zero", 2'd1, 1'b0, -150, 32'h8000_0000, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 1, 0, 1);
    run("R9 tie up mode", 2'd1, 1'b0, -150, 32'h8000_0000, 1'b0, 2'd2, 1'b0, 32'h0000_0001, 1, 0, 1);
    run("R9 far below", 2'd1, 1'b0, -1000, 32'h8000_0000, 1'b0, 2'd2, 1'b0, 32'h0000_0001, 1, 0, 1);
  endtask

  task automatic t_promote;
    run("R10 near", 2'd1, 1'b0, -127, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0, 32'h0080_0000, 1, 0, 0);
    run("R10 up pos", 2'd1, 1'b0, -127, 32'hFFFF_FFFF, 1'b0, 2'd2, 1'b1, 32'h0080_0000, 1, 0, 0);
    run("R10 down neg", 2'd1, 1'b1, -127, 32'hFFFF_FFFF, 1'b0, 2'd3, 1'b0, 32'h8080_0000, 1, 0, 0);
    run("R10 zero stays", 2'd1, 1'b0, -127, 32'hFFFF_FFFF, 1'b0, 2'd1, 1'b0, 32'h007F_FFFF, 1, 0, 1);
    run("R10 down pos stays", 2'd1, 1'b0, -127, 32'hFFFF_FFFF, 1'b0, 2'd3, 1'b0, 32'h007F_FFFF, 1, 0, 1);
  endtask

  task automatic t_underflow;
    run("R11 exact no trap", 2'd1, 1'b0, -127, 32'h8000_0000, 1'b0, 2'd0, 1'b0, 32'h0040_0000, 0, 0, 0);
    run("R11 exact trap", 2'd1, 1'b0, -127, 32'h8000_0000, 1'b0, 2'd0, 1'b1, 32'h0040_0000, 0, 0, 1);
    run("R11 normal trap", 2'd1, 1'b0, 0, 32'h8000_0001, 1'b0, 2'd1, 1'b1, 32'h3F80_0000, 1, 0, 0);
  endtask

  task automatic t_idle;
    run("R1 load", 2'd1, 1'b0, 0, 32'h8000_0000, 1'b0, 2'd0, 1'b0, 32'h3F80_0000, 0, 0, 0);
    in_class = 2'd1; in_sign = 1'b1; in_exp = EW'(128); in_mant = 32'hFFFF_FFFF;
    rnd_mode = 2'd0; uf_trap_en = 1'b1;
    @(negedge clk);
    check("R1 idle hold", {out_valid, out_word, flag_nx, flag_of, flag_uf},
          {1'b0, 32'h3F80_0000, 1'b0, 1'b0, 1'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_specials();
    t_normal();
    t_round();
    t_carry();
    t_overflow();
    t_subnormal();
    t_promote();
    t_underflow();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule